// File: doc/BRIEF.md
# Interrupt Vector Translator with Single Pending Slot

This block sits between a set of interrupt sources and one processor. Sources post an event made of a valid strobe and a value. When translation is switched on, the value is searched for in a small programmable table of (value, vector) pairs. When it is switched off, the low bits of the value are used directly as the vector. The block keeps exactly one pending vector and presents it to the processor on every cycle until the processor accepts it.

A second, different interrupt can arrive while one is still waiting. A selectable collision policy then decides the outcome. The block can flag an error and keep the old vector, let the newer vector take the slot, or put a fixed substitute vector in the slot. Error conditions go to a sticky flag that only reset or an explicit clear can lower.

The table is written through a simple port of index plus entry data. Writes are refused while a vector is pending, so the mapping cannot shift under an undelivered interrupt.

Top module: `irq_vec_xlate`

## Requirements
- R1: An event whose value is zero changes nothing: the pending vector, the request and the error flag are all left as they were.
- R2: With translation off (`xlate_en`=0), the vector is the low VEC_W bits of the value. An event whose low VEC_W bits are all zero changes nothing.
- R3: With translation on, entries are searched from index 0 upward and the first entry whose value matches supplies the vector. An entry whose value is zero ends the search, and entries above it are not consulted.
- R4: With translation on and no matching entry, the error flag is set one cycle later and the pending vector is unchanged.
- R5: If a vector is pending and the new vector equals it, the event is dropped with no error.
- R6: Policy code 0 (and code 3): a different vector arriving while one is pending sets the error flag and keeps the old vector pending.
- R7: Policy code 1: a different vector arriving while one is pending replaces the pending vector.
- R8: Policy code 2: a different vector arriving while one is pending makes `subst_vector` the pending vector.
- R9: `cpu_req` is high and `cpu_vector` holds the pending vector on every cycle until `cpu_ack` is seen. After the accept edge, `cpu_vector` is zero and `cpu_req` is low.
- R10: If `cpu_ack` and a nonzero event fall in the same cycle, the old vector is retired and the new vector becomes pending, with no collision.
- R11: Table writes are ignored in any cycle where `cpu_req` is high.
- R12: The error flag stays set until `err_clr` or reset. When a new error and `err_clr` fall in the same cycle, the flag stays set.
- R13: After synchronous reset, `cpu_req`=0, `cpu_vector`=0, `err`=0, and every table entry is zero, so a lookup with translation on misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_value | input | VAL_W | Value carried by the event |
| xlate_en | input | 1 | 1: look the value up in the table; 0: use its low bits |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_value | input | VAL_W | Entry match value (0 ends the table) |
| tbl_wr_vector | input | VEC_W | Entry vector |
| policy | input | 2 | Collision policy: 0/3 error, 1 replace, 2 substitute |
| subst_vector | input | VEC_W | Vector used by policy 2 |
| cpu_req | output | 1 | A vector is pending |
| cpu_vector | output | VEC_W | Pending vector, zero when none |
| cpu_ack | input | 1 | Processor accepts the pending vector |
| err_clr | input | 1 | Clears the sticky error flag |
| err | output | 1 | Sticky error flag |

## Verification
The bench builds the block with a four-entry table, 12-bit values and 6-bit vectors. With four entries, the table can be filled completely, so a search that runs past the last entry without meeting a terminator is exercised. It also makes a terminator placed mid-table easy to reach. With 6-bit vectors, values whose low bits are zero show how the pass-through mode truncates. A random phase draws values from a small set that overlaps the table, so hits, misses, same-vector drops and collisions under every policy all recur many times.

// File: rtl/irq_xlate_pkg.sv
package irq_xlate_pkg;

  // Collision policy encoding; code 3 behaves as the error policy.
  typedef enum logic [1:0] {
    POL_ERROR   = 2'd0,
    POL_REPLACE = 2'd1,
    POL_SUBST   = 2'd2,
    POL_ERROR_B = 2'd3
  } coll_pol_e;

  // Outcome of offering a candidate vector to the pending slot.
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_LOAD  = 2'd1,
    OUT_DROP  = 2'd2,
    OUT_FAULT = 2'd3
  } slot_out_e;

endpackage

// File: rtl/irq_xlate_table.sv
module irq_xlate_table #(
  parameter int DEPTH = 8,
  parameter int VAL_W = 16,
  parameter int VEC_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_value,
  input  logic [VEC_W-1:0] wr_vector,
  input  logic [VAL_W-1:0] lk_value,
  output logic             lk_hit,
  output logic [VEC_W-1:0] lk_vector
);

  logic [VAL_W-1:0] ent_val [DEPTH];
  logic [VEC_W-1:0] ent_vec [DEPTH];
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] match;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_val[g] <= '0;
          ent_vec[g] <= '0;
        end else if (wr_en && (int'(wr_idx) == g)) begin
          ent_val[g] <= wr_value;
          ent_vec[g] <= wr_vector;
        end
      end

      // An entry counts only if it and every entry below it are nonzero.
      if (g == 0) begin : g_first
        assign live[g] = (ent_val[g] != '0);
      end else begin : g_rest
        assign live[g] = live[g-1] && (ent_val[g] != '0);
      end

      assign match[g] = live[g] && (ent_val[g] == lk_value);
    end
  endgenerate

  // Lowest matching index wins.
  always_comb begin
    lk_hit    = 1'b0;
    lk_vector = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit    = 1'b1;
        lk_vector = ent_vec[i];
      end
    end
  end

endmodule

// File: rtl/irq_pend_slot.sv
module irq_pend_slot
  import irq_xlate_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             cand_ok,
  input  logic [VEC_W-1:0] cand_vec,
  input  logic [1:0]       policy,
  input  logic [VEC_W-1:0] subst_vec,
  output logic [VEC_W-1:0] pend_vec,
  output logic             fault
);

  logic [VEC_W-1:0] base_vec;
  slot_out_e        outcome;
  logic [VEC_W-1:0] load_vec;

  // Classifies a candidate against the slot contents left after any accept.
  function automatic slot_out_e classify(input logic ok,
                                         input logic [VEC_W-1:0] cur,
                                         input logic [VEC_W-1:0] cand,
                                         input logic [1:0] pol);
    if (!ok)                          return OUT_NONE;
    if (cur == '0)                    return OUT_LOAD;
    if (cand == cur)                  return OUT_DROP;
    if (coll_pol_e'(pol) == POL_REPLACE ||
        coll_pol_e'(pol) == POL_SUBST) return OUT_LOAD;
    return OUT_FAULT;
  endfunction

  assign base_vec = ack ? '0 : pend_vec;
  assign outcome  = classify(cand_ok, base_vec, cand_vec, policy);
  assign load_vec = (base_vec != '0 && coll_pol_e'(policy) == POL_SUBST)
                    ? subst_vec : cand_vec;
  assign fault    = (outcome == OUT_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vec <= '0;
    end else if (outcome == OUT_LOAD) begin
      pend_vec <= load_vec;
    end else begin
      pend_vec <= base_vec;
    end
  end

endmodule

// File: rtl/irq_err_flag.sv
module irq_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/irq_vec_xlate.sv
module irq_vec_xlate #(
  parameter int DEPTH = 8,
  parameter int VAL_W = 16,
  parameter int VEC_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [VAL_W-1:0] evt_value,
  input  logic             xlate_en,
  input  logic             tbl_wr_en,
  input  logic [IDX_W-1:0] tbl_wr_idx,
  input  logic [VAL_W-1:0] tbl_wr_value,
  input  logic [VEC_W-1:0] tbl_wr_vector,
  input  logic [1:0]       policy,
  input  logic [VEC_W-1:0] subst_vector,
  output logic             cpu_req,
  output logic [VEC_W-1:0] cpu_vector,
  input  logic             cpu_ack,
  input  logic             err_clr,
  output logic             err
);

  // Named internal events, also watched by the checker.
  logic             evt_take;
  logic             lk_hit;
  logic [VEC_W-1:0] lk_vector;
  logic             lk_miss;
  logic [VEC_W-1:0] mapped_vec;
  logic             cand_ok;
  logic             abort_evt;
  logic             tbl_wr_ok;

  assign evt_take   = evt_valid && (evt_value != '0);
  assign tbl_wr_ok  = tbl_wr_en && !cpu_req;
  assign lk_miss    = evt_take && xlate_en && !lk_hit;
  assign mapped_vec = xlate_en ? lk_vector : evt_value[VEC_W-1:0];
  assign cand_ok    = evt_take && !lk_miss && (mapped_vec != '0);

  irq_xlate_table #(
    .DEPTH(DEPTH), .VAL_W(VAL_W), .VEC_W(VEC_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_wr_ok),
    .wr_idx   (tbl_wr_idx),
    .wr_value (tbl_wr_value),
    .wr_vector(tbl_wr_vector),
    .lk_value (evt_value),
    .lk_hit   (lk_hit),
    .lk_vector(lk_vector)
  );

  irq_pend_slot #(
    .VEC_W(VEC_W)
  ) u_slot (
    .clk      (clk),
    .rst      (rst),
    .ack      (cpu_ack),
    .cand_ok  (cand_ok),
    .cand_vec (mapped_vec),
    .policy   (policy),
    .subst_vec(subst_vector),
    .pend_vec (cpu_vector),
    .fault    (abort_evt)
  );

  irq_err_flag u_err (
    .clk (clk),
    .rst (rst),
    .set (lk_miss || abort_evt),
    .clr (err_clr),
    .flag(err)
  );

  assign cpu_req = (cpu_vector != '0);

endmodule

// File: rtl/irq_vec_xlate_chk.sv
module irq_vec_xlate_chk #(
  parameter int VAL_W = 16,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_valid,
  input logic [VAL_W-1:0] evt_value,
  input logic             cpu_req,
  input logic [VEC_W-1:0] cpu_vector,
  input logic             cpu_ack,
  input logic             err,
  input logic             err_clr,
  input logic             lk_miss,
  input logic             cand_ok,
  input logic [VEC_W-1:0] mapped_vec,
  input logic             abort_evt
);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_ack && !evt_valid) |=> (cpu_req && $stable(cpu_vector))); // R9

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ack && !evt_valid) |=> !cpu_req); // R9

  AST_ZERO_VALUE_INERT: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_value == '0 && !cpu_ack) |=> $stable(cpu_vector)); // R1

  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    lk_miss |=> err); // R4

  AST_SAME_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_ack && cand_ok && mapped_vec == cpu_vector && !lk_miss)
      |=> $stable(cpu_vector)); // R5

  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> (err && $stable(cpu_vector))); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err); // R12

  AST_ACK_EVENT_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ack && cand_ok) |=> (cpu_vector == $past(mapped_vec))); // R10

endmodule

bind irq_vec_xlate irq_vec_xlate_chk #(.VAL_W(VAL_W), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .evt_value (evt_value),
  .cpu_req   (cpu_req),
  .cpu_vector(cpu_vector),
  .cpu_ack   (cpu_ack),
  .err       (err),
  .err_clr   (err_clr),
  .lk_miss   (lk_miss),
  .cand_ok   (cand_ok),
  .mapped_vec(mapped_vec),
  .abort_evt (abort_evt)
);

// File: tb/irq_vec_xlate_test.sv
module irq_vec_xlate_test;

  localparam int DEPTH = 4;
  localparam int VW    = 12;
  localparam int CW    = 6;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_valid = 1'b0;
  logic [VW-1:0] evt_value = '0;
  logic          xlate_en = 1'b0;
  logic          tbl_wr_en = 1'b0;
  logic [IW-1:0] tbl_wr_idx = '0;
  logic [VW-1:0] tbl_wr_value = '0;
  logic [CW-1:0] tbl_wr_vector = '0;
  logic [1:0]    policy = 2'd0;
  logic [CW-1:0] subst_vector = '0;
  logic          cpu_req;
  logic [CW-1:0] cpu_vector;
  logic          cpu_ack = 1'b0;
  logic          err_clr = 1'b0;
  logic          err;

  irq_vec_xlate #(.DEPTH(DEPTH), .VAL_W(VW), .VEC_W(CW)) uut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_value(evt_value),
    .xlate_en(xlate_en), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_value(tbl_wr_value), .tbl_wr_vector(tbl_wr_vector),
    .policy(policy), .subst_vector(subst_vector), .cpu_req(cpu_req),
    .cpu_vector(cpu_vector), .cpu_ack(cpu_ack), .err_clr(err_clr), .err(err)
  );

  always #4 clk = ~clk;  // 125 MHz

  // Behavioural reference state.
  int    m_tv [DEPTH];
  int    m_tc [DEPTH];
  int    m_pend;
  bit    m_err;
  int    n_checks = 0;
  int    n_fail   = 0;
  string tag = "R13";

  task automatic compare();
    n_checks++;
    if (cpu_req !== (m_pend != 0) || int'(cpu_vector) != m_pend || err !== m_err) begin
      n_fail++;
      $display("FAIL %s: req=%0b vec=%0d err=%0b expected req=%0b vec=%0d err=%0b",
               tag, cpu_req, cpu_vector, err, (m_pend != 0), m_pend, m_err);
    end
  endtask

  // One clock: predict from inputs now applied, then compare at the next low phase.
  task automatic step();
    int  np;
    bit  ne;
    int  base;
    int  v;
    bit  found;
    int  val;
    val  = int'(evt_value);
    base = (cpu_ack) ? 0 : m_pend;
    np   = base;
    ne   = m_err;
    if (err_clr) ne = 1'b0;
    if (evt_valid && val != 0) begin
      found = 1'b0;
      v     = 0;
      if (!xlate_en) begin
        v = val % (1 << CW);        // R2
        found = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin   // R3
          if (m_tv[i] == 0) break;
          if (m_tv[i] == val) begin
            v = m_tc[i];
            found = 1'b1;
            break;
          end
        end
      end
      if (!found) ne = 1'b1;                    // R4
      else if (v != 0) begin
        if (base == 0) np = v;
        else if (v == base) np = base;          // R5
        else if (policy == 2'd1) np = v;        // R7
        else if (policy == 2'd2) np = int'(subst_vector); // R8
        else ne = 1'b1;                         // R6
      end
    end
    if (tbl_wr_en && m_pend == 0) begin         // R11
      m_tv[tbl_wr_idx] = int'(tbl_wr_value);
      m_tc[tbl_wr_idx] = int'(tbl_wr_vector);
    end
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      m_pend = 0;
      m_err  = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin m_tv[i] = 0; m_tc[i] = 0; end
    end else begin
      m_pend = np;
      m_err  = ne;
    end
    evt_valid = 1'b0;
    tbl_wr_en = 1'b0;
    cpu_ack   = 1'b0;
    err_clr   = 1'b0;
    compare();
  endtask

  task automatic ev(input int value);
    evt_valid = 1'b1;
    evt_value = VW'(value);
    step();
  endtask

  task automatic wr(input int idx, input int value, input int vec);
    tbl_wr_en     = 1'b1;
    tbl_wr_idx    = IW'(idx);
    tbl_wr_value  = VW'(value);
    tbl_wr_vector = CW'(vec);
    step();
  endtask

  task automatic ack();
    cpu_ack = 1'b1;
    step();
  endtask

  task automatic clr();
    err_clr = 1'b1;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    m_pend = 0;
    m_err  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin m_tv[i] = 0; m_tc[i] = 0; end
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    tag = "R13"; idle(2);
    xlate_en = 1'b1; ev(12'h005);        // empty table after reset misses
    tag = "R12"; clr();

    // Pass-through mode
    xlate_en = 1'b0;
    tag = "R2";  ev(12'h0A5);            // vector 0x25
    tag = "R9";  idle(3);
    tag = "R1";  ev(0); idle(1);
    tag = "R2";  ev(12'h040);            // low bits zero: no effect, no error
    tag = "R9";  ack(); idle(1);

    // Table contents: duplicate value at idx2 must lose to idx0
    tag = "R11";
    wr(0, 12'h111, 3); wr(1, 12'h222, 7); wr(2, 12'h111, 9); wr(3, 12'h333, 12);
    xlate_en = 1'b1;
    tag = "R3";  ev(12'h111);
    tag = "R11"; wr(0, 12'h555, 20); ack();
    ev(12'h555); clr();                  // refused write leaves 0x555 unmapped
    tag = "R3";  ev(12'h111); ack();
    ev(12'h333); ack();                  // full table, last entry
    wr(1, 0, 0);
    ev(12'h333);                         // idx1 terminates the search
    tag = "R4";  ev(12'h444); clr();
    wr(1, 12'h222, 7);

    // Collisions
    tag = "R5";  ev(12'h111); ev(12'h111); idle(1);
    tag = "R6";  policy = 2'd0; ev(12'h222); clr();
    policy = 2'd3; ev(12'h333); clr();
    tag = "R7";  policy = 2'd1; ev(12'h222); idle(1); ack();
    tag = "R8";  policy = 2'd2; subst_vector = 6'd45;
    ev(12'h111); ev(12'h333); idle(1); ack();
    tag = "R10"; policy = 2'd0; ev(12'h111);
    cpu_ack = 1'b1; ev(12'h222); idle(1);
    tag = "R12"; err_clr = 1'b1; ev(12'h111); idle(1); clr(); ack();

    // Mixed random traffic
    tag = "mix";
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = int'($urandom_range(0, 7));
      evt_valid = ($urandom_range(0, 2) != 0);
      case (sel)
        0: evt_value = 12'h000;
        1: evt_value = 12'h111;
        2: evt_value = 12'h222;
        3: evt_value = 12'h333;
        4: evt_value = 12'h0C0;
        5: evt_value = 12'h455;
        default: evt_value = VW'($urandom_range(0, 4095));
      endcase
      xlate_en      = ($urandom_range(0, 3) != 0);
      policy        = 2'($urandom_range(0, 3));
      subst_vector  = CW'($urandom_range(1, 63));
      cpu_ack       = ($urandom_range(0, 3) == 0);
      err_clr       = ($urandom_range(0, 5) == 0);
      tbl_wr_en     = ($urandom_range(0, 9) == 0);
      tbl_wr_idx    = IW'($urandom_range(0, DEPTH - 1));
      tbl_wr_value  = (sel > 3) ? VW'(12'h111) : VW'(12'h100 * sel + 12'h011 * sel);
      tbl_wr_vector = CW'($urandom_range(0, 63));
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule